// File: doc/BRIEF.md
# Ethernet MAC configuration register bank

This block holds the configuration words of a 10 Gb/s Ethernet MAC and presents them to the transmit, receive, flow-control and reconciliation logic. A host reaches it through a processor-neutral port: a 2-bit opcode, a 10-bit address, and 32-bit write and read buses. When the select input routes a host access to the management-serial or statistics path, the bank ignores that access.

Every register exists twice. The host writes a staging copy. An active copy drives the configuration outputs and takes the staging contents on any cycle where `ifg_idle` is high, so a setting never changes in the middle of a frame. The two soft-reset bits are the exception: they reach their outputs one cycle after the write, whatever `ifg_idle` does. The reconciliation word also returns four live status flags: local fault, remote fault, and the lock flags of the transmit and receive clocks.

Top module: `macreg_bank`

## Requirements
- R1: After reset, `rx_cfg` is 6'b001000, `tx_cfg` is 8'b00100000, `fc_en` is 2'b11, and every other configuration output and `host_rdata` is 0.
- R2: A write is performed when `host_sel` is 0 and `host_op[1]` is 0. The value of `host_op[0]` makes no difference to configuration writes or reads.
- R3: While `host_sel` is 1, no register is written, and `host_rdata` is 0 in the following cycle.
- R4: A write changes only the staging copy. The configuration outputs change only in the cycle after a cycle with `ifg_idle` high, and they then show the staging contents as they stood before that edge.
- R5: `rx_rst` follows bit 31 of the word at 0x240, and `tx_rst` follows bit 31 of the word at 0x280. Each updates in the cycle after the write, independent of `ifg_idle`.
- R6: When `host_sel` is 0 and `host_op[1]` is 1, `host_rdata` shows the staged word at `host_addr` one cycle later. Reserved bits read 0. In every other cycle `host_rdata` is 0.
- R7: A read of 0x300 returns, as sampled at the read edge, `rx_lock` on bit 31, `tx_lock` on bit 30, `remote_fault` on bit 29 and `local_fault` on bit 28. Fault inhibit is on bit 27 and is writable. Writes to bits 31:28 are ignored.
- R8: A read of any address other than 0x200, 0x240, 0x280, 0x2C0, 0x300 or 0x340 returns 0. A write to such an address changes no register.
- R9: The pause address is 48 bits. Bits 31:0 come from 0x200 and bits 47:32 from 0x240 bits 15:0.
- R10: Word 0x240 bits 30:25 map to `rx_cfg[5:0]`: length/type check disable, preserve preamble, VLAN, receive enable, in-band FCS, jumbo. Word 0x280 bits 30:23 map to `tx_cfg[7:0]`: preserve preamble, deficit idle count, IFG adjust, WAN mode, VLAN, transmit enable, in-band FCS, jumbo. Word 0x2C0 bits 30:29 map to `fc_en[1:0]`: bit 1 is transmit and bit 0 is receive. Word 0x340 bits 4:0 give `mdc_div` and bit 5 gives `mdio_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_op | input | 2 | Opcode; bit 1 low means write |
| host_addr | input | 10 | Register address |
| host_wdata | input | 32 | Write data |
| host_sel | input | 1 | High routes the access to the serial-management/statistics path |
| host_rdata | output | 32 | Registered read data |
| ifg_idle | input | 1 | High in interframe-gap cycles; commits staged values |
| local_fault | input | 1 | Local fault status |
| remote_fault | input | 1 | Remote fault status |
| tx_lock | input | 1 | Transmit clock locked |
| rx_lock | input | 1 | Receive clock locked |
| pause_mac | output | 48 | Active pause-frame MAC address |
| rx_cfg | output | 6 | Active receive enables |
| tx_cfg | output | 8 | Active transmit enables |
| fc_en | output | 2 | Active flow-control enables |
| fault_inhibit | output | 1 | Active fault inhibit |
| mdc_div | output | 5 | Active management clock divide |
| mdio_en | output | 1 | Active management enable |
| rx_rst | output | 1 | Receiver soft reset |
| tx_rst | output | 1 | Transmitter soft reset |

## Verification
The assertions check four properties on every cycle. The active outputs hold still unless the previous cycle was a gap. The reset outputs move only after a write to their own word. Routed-away accesses and unmapped reads return zero. The reserved bits of the flow-control word read as zero.

Other behaviour needs the bench's scenarios and its reference model. These cover which value a commit actually carries, a write landing in the same cycle as a commit, the field positions, the live status bits, and the fact that `host_op[0]` has no effect.

// File: rtl/macreg_bank.sv
module macreg_bank #(
  parameter logic [9:0] A_PLO = 10'h200,
  parameter logic [9:0] A_W1  = 10'h240,
  parameter logic [9:0] A_TX  = 10'h280,
  parameter logic [9:0] A_FC  = 10'h2C0,
  parameter logic [9:0] A_RS  = 10'h300,
  parameter logic [9:0] A_MG  = 10'h340
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  host_op,
  input  logic [9:0]  host_addr,
  input  logic [31:0] host_wdata,
  input  logic        host_sel,
  output logic [31:0] host_rdata,
  input  logic        ifg_idle,
  input  logic        local_fault,
  input  logic        remote_fault,
  input  logic        tx_lock,
  input  logic        rx_lock,
  output logic [47:0] pause_mac,
  output logic [5:0]  rx_cfg,
  output logic [7:0]  tx_cfg,
  output logic [1:0]  fc_en,
  output logic        fault_inhibit,
  output logic [4:0]  mdc_div,
  output logic        mdio_en,
  output logic        rx_rst,
  output logic        tx_rst
);
  localparam logic [5:0] RX_DEF = 6'b001000;
  localparam logic [7:0] TX_DEF = 8'b00100000;

  logic        wr, rd;
  logic [47:0] s_pa, a_pa;
  logic [5:0]  s_rx, a_rx, s_mg, a_mg;
  logic [7:0]  s_tx, a_tx;
  logic [1:0]  s_fc, a_fc;
  logic        s_fi, a_fi, rx_rst_q, tx_rst_q;

  assign wr = !host_sel && !host_op[1];
  assign rd = !host_sel &&  host_op[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_pa <= '0; s_rx <= RX_DEF; s_tx <= TX_DEF; s_fc <= 2'b11;
      s_fi <= 1'b0; s_mg <= '0; rx_rst_q <= 1'b0; tx_rst_q <= 1'b0;
    end else if (wr) begin
      case (host_addr)
        A_PLO: s_pa[31:0] <= host_wdata;
        A_W1: begin
          s_pa[47:32] <= host_wdata[15:0];
          s_rx        <= host_wdata[30:25];
          rx_rst_q    <= host_wdata[31];
        end
        A_TX: begin
          s_tx     <= host_wdata[30:23];
          tx_rst_q <= host_wdata[31];
        end
        A_FC: s_fc <= host_wdata[30:29];
        A_RS: s_fi <= host_wdata[27];
        A_MG: s_mg <= host_wdata[5:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_pa <= '0; a_rx <= RX_DEF; a_tx <= TX_DEF; a_fc <= 2'b11;
      a_fi <= 1'b0; a_mg <= '0;
    end else if (ifg_idle) begin
      a_pa <= s_pa; a_rx <= s_rx; a_tx <= s_tx; a_fc <= s_fc;
      a_fi <= s_fi; a_mg <= s_mg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) host_rdata <= '0;
    else begin
      host_rdata <= '0;
      if (rd) begin
        case (host_addr)
          A_PLO: host_rdata <= s_pa[31:0];
          A_W1:  host_rdata <= {rx_rst_q, s_rx, 9'b0, s_pa[47:32]};
          A_TX:  host_rdata <= {tx_rst_q, s_tx, 23'b0};
          A_FC:  host_rdata <= {1'b0, s_fc, 29'b0};
          A_RS:  host_rdata <= {rx_lock, tx_lock, remote_fault, local_fault, s_fi, 27'b0};
          A_MG:  host_rdata <= {26'b0, s_mg};
          default: ;
        endcase
      end
    end
  end

  assign pause_mac     = a_pa;
  assign rx_cfg        = a_rx;
  assign tx_cfg        = a_tx;
  assign fc_en         = a_fc;
  assign fault_inhibit = a_fi;
  assign mdc_div       = a_mg[4:0];
  assign mdio_en       = a_mg[5];
  assign rx_rst        = rx_rst_q;
  assign tx_rst        = tx_rst_q;
endmodule

module macreg_bank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  host_op,
  input logic [9:0]  host_addr,
  input logic        host_sel,
  input logic [31:0] host_rdata,
  input logic        ifg_idle,
  input logic [47:0] pause_mac,
  input logic [5:0]  rx_cfg,
  input logic [7:0]  tx_cfg,
  input logic [1:0]  fc_en,
  input logic        fault_inhibit,
  input logic [4:0]  mdc_div,
  input logic        mdio_en,
  input logic        rx_rst,
  input logic        tx_rst
);
  logic mapped;
  assign mapped = host_addr inside {10'h200, 10'h240, 10'h280, 10'h2C0, 10'h300, 10'h340};

  // R4
  hold_outside_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ifg_idle) |-> ($stable(pause_mac) && $stable(rx_cfg) && $stable(tx_cfg) &&
                          $stable(fc_en) && $stable(fault_inhibit) && $stable(mdc_div) && $stable(mdio_en)));
  // R5
  rx_rst_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_rst) |-> $past(!host_sel && !host_op[1] && host_addr == 10'h240));
  // R5
  tx_rst_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tx_rst) |-> $past(!host_sel && !host_op[1] && host_addr == 10'h280));
  // R3
  sel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_sel |=> host_rdata == 32'h0);
  // R8
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_sel && host_op[1] && !mapped) |=> host_rdata == 32'h0);
  // R6
  fc_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_sel && host_op[1] && host_addr == 10'h2C0) |=> (host_rdata[31] == 1'b0 && host_rdata[28:0] == 29'h0));
endmodule

bind macreg_bank macreg_bank_chk u_chk (.*);

// File: tb/test_macreg_bank.sv
`timescale 1ns/1ps
module test_macreg_bank;
  logic clk = 0, rst_n = 0;
  logic [1:0] op = 2'b10;
  logic [9:0] addr = 0;
  logic [31:0] wd = 0, rdata;
  logic sel = 0, idle = 0, lf = 0, rf = 0, tl = 0, rl = 0;
  logic [47:0] pause_mac;
  logic [5:0] rx_cfg;
  logic [7:0] tx_cfg;
  logic [1:0] fc_en;
  logic fault_inhibit, mdio_en, rx_rst, tx_rst;
  logic [4:0] mdc_div;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  macreg_bank i_macreg_bank (
    .clk(clk), .rst_n(rst_n), .host_op(op), .host_addr(addr), .host_wdata(wd),
    .host_sel(sel), .host_rdata(rdata), .ifg_idle(idle), .local_fault(lf),
    .remote_fault(rf), .tx_lock(tl), .rx_lock(rl), .pause_mac(pause_mac),
    .rx_cfg(rx_cfg), .tx_cfg(tx_cfg), .fc_en(fc_en), .fault_inhibit(fault_inhibit),
    .mdc_div(mdc_div), .mdio_en(mdio_en), .rx_rst(rx_rst), .tx_rst(tx_rst));

  logic [31:0] s[6], a[6], ns[6], na[6], erd;
  localparam logic [31:0] WMASK[6] = '{32'hFFFF_FFFF, 32'hFE00_FFFF, 32'hFF80_0000,
                                       32'h6000_0000, 32'h0800_0000, 32'h0000_003F};

  function automatic int slot(input logic [9:0] ad);
    case (ad)
      10'h200: return 0; 10'h240: return 1; 10'h280: return 2;
      10'h2C0: return 3; 10'h300: return 4; 10'h340: return 5;
      default: return -1;
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "rdata R6", {32'h0, rdata}, {32'h0, erd});
    chk(tag, "pause_mac R9", {16'h0, pause_mac}, {16'h0, a[1][15:0], a[0]});
    chk(tag, "rx_cfg R10", {58'h0, rx_cfg}, {58'h0, a[1][30:25]});
    chk(tag, "tx_cfg R10", {56'h0, tx_cfg}, {56'h0, a[2][30:23]});
    chk(tag, "fc_en R4", {62'h0, fc_en}, {62'h0, a[3][30:29]});
    chk(tag, "mgmt R4", {57'h0, fault_inhibit, mdio_en, mdc_div}, {57'h0, a[4][27], a[5][5:0]});
    chk(tag, "resets R5", {62'h0, rx_rst, tx_rst}, {62'h0, s[1][31], s[2][31]});
  endtask

  task automatic cyc(input logic [1:0] o, input logic [9:0] ad, input logic [31:0] d,
                     input logic sl, input logic id, input string tag);
    int i;
    logic [31:0] r;
    op = o; addr = ad; wd = d; sel = sl; idle = id;
    i = slot(ad);
    r = 0;
    if (!sl && o[1] && i >= 0) r = (i == 4) ? (s[4] | {rl, tl, rf, lf, 28'h0}) : s[i];
    for (int k = 0; k < 6; k++) begin
      ns[k] = s[k];
      na[k] = id ? s[k] : a[k];
    end
    if (!sl && !o[1] && i >= 0) ns[i] = (s[i] & ~WMASK[i]) | (d & WMASK[i]);
    @(posedge clk); @(negedge clk);
    for (int k = 0; k < 6; k++) begin s[k] = ns[k]; a[k] = na[k]; end
    erd = r;
    compare(tag);
  endtask

  initial begin
    #(200000 * 4);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    s = '{32'h0, 32'h1000_0000, 32'h1000_0000, 32'h6000_0000, 32'h0, 32'h0};
    a = s; erd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    compare("R1");
    // R4: staged only, then commit
    cyc(2'b00, 10'h280, 32'hFFFF_FFFF, 0, 0, "R4");
    cyc(2'b10, 10'h000, 0, 0, 0, "R4");
    chk("R4", "tx_cfg held", {56'h0, tx_cfg}, {56'h0, 8'b00100000});
    cyc(2'b10, 10'h000, 0, 0, 1, "R4");
    cyc(2'b10, 10'h000, 0, 0, 0, "R4");
    chk("R4", "tx_cfg committed", {56'h0, tx_cfg}, 64'hFF);
    // R5: reset bits immediate
    cyc(2'b00, 10'h240, 32'h8000_0000, 0, 0, "R5");
    chk("R5", "rx_rst", {63'h0, rx_rst}, 64'h1);
    cyc(2'b00, 10'h280, 32'h0, 0, 0, "R5");
    chk("R5", "tx_rst cleared", {63'h0, tx_rst}, 64'h0);
    // R2: op[0] ignored
    cyc(2'b01, 10'h340, 32'hFFFF_FF35, 0, 1, "R2");
    cyc(2'b11, 10'h340, 0, 0, 1, "R2");
    chk("R2", "mgmt readback", {32'h0, rdata}, 64'h35);
    // R3: select routes away
    cyc(2'b00, 10'h300, 32'hFFFF_FFFF, 1, 1, "R3");
    cyc(2'b10, 10'h300, 0, 1, 1, "R3");
    chk("R3", "rdata while sel", {32'h0, rdata}, 64'h0);
    cyc(2'b10, 10'h300, 0, 0, 1, "R3");
    // R7: live status
    {rl, tl, rf, lf} = 4'b1010;
    cyc(2'b00, 10'h300, 32'hF800_0000, 0, 1, "R7");
    cyc(2'b10, 10'h300, 0, 0, 0, "R7");
    chk("R7", "rs word", {32'h0, rdata}, 64'hA800_0000);
    // R8: unmapped
    cyc(2'b00, 10'h3C0, 32'hFFFF_FFFF, 0, 1, "R8");
    cyc(2'b00, 10'h201, 32'hFFFF_FFFF, 0, 1, "R8");
    cyc(2'b10, 10'h201, 0, 0, 0, "R8");
    chk("R8", "unmapped read", {32'h0, rdata}, 64'h0);
    // R9: pause address split
    cyc(2'b00, 10'h200, 32'h89AB_CDEF, 0, 0, "R9");
    cyc(2'b00, 10'h240, 32'h1000_4567, 0, 0, "R9");
    cyc(2'b10, 10'h240, 0, 0, 1, "R9");
    cyc(2'b10, 10'h2C0, 0, 0, 0, "R9");
    chk("R9", "pause_mac", {16'h0, pause_mac}, 64'h4567_89AB_CDEF);
    // R10: field positions
    cyc(2'b00, 10'h240, 32'h2200_0000, 0, 1, "R10");
    cyc(2'b10, 10'h000, 0, 0, 1, "R10");
    chk("R10", "rx_cfg", {58'h0, rx_cfg}, 64'h11);
    // mixed traffic
    for (int n = 0; n < 600; n++) begin
      logic [9:0] ad;
      ad = ($urandom % 8 == 0) ? 10'($urandom) : 10'h200 + 10'(($urandom % 6) * 64);
      {rl, tl, rf, lf} = 4'($urandom);
      cyc(2'($urandom), ad, $urandom, ($urandom % 6) == 0, ($urandom % 3) == 0, "R4");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule